// File: doc/BRIEF.md
# Main/Auxiliary RAM Bank Decoder

This block is a purely combinational decoder for a 16-bit address space belonging to an 8-bit processor that has two 64 KB RAM banks. The banks are called base and auxiliary. For every access the decoder looks at the address, the direction of the access, a set of memory mode flags and the current language-card state. From these it picks exactly one target: base RAM, auxiliary RAM, ROM or the I/O space. It picks no target at all when a write falls in a write-protected language-card window or when the access lands in the peripheral-slot window.

The mode flags route reads and writes independently. One flag steers the zero page and the stack. One flag steers reads and another steers writes in the general RAM area. A display-store flag, combined with a page flag (and a graphics flag for the high-resolution page), overrides the read and write flags inside the two display pages.

The decoder also produces the physical RAM address. In the D000–DFFF window this address folds the first of the two 4 KB banks down into the C000–CFFF range of the RAM array. That range of the array is otherwise never reachable, because those addresses decode to I/O and slot space.

Top module: `bank_decoder`

## Requirements
- R1: For 0000–01FF, both reads and writes select auxiliary RAM when `altZp`=1, and select base RAM when `altZp`=0.
- R2: For 0200–BFFF outside the two display pages, a read selects auxiliary RAM when `auxRead`=1 and base RAM otherwise. A write selects auxiliary RAM when `auxWrite`=1 and base RAM otherwise.
- R3: For 0400–07FF, the rule depends on `store80`. With `store80`=1, the access selects auxiliary RAM exactly when `page2`=1. With `store80`=0, the access follows the R2 rule for its direction.
- R4: For 2000–3FFF, the rule also depends on `store80`. With `store80`=1, the access selects auxiliary RAM only when both `page2`=1 and `hiRes`=1, and selects base RAM otherwise. With `store80`=0, the access follows the R2 rule for its direction.
- R5: For C000–C0FF, only `selIo` is asserted, whatever the flags and direction.
- R6: For C100–CFFF, no select output is asserted.
- R7: For D000–FFFF reads, `selRom` is asserted when `lcReadRam`=0. When `lcReadRam`=1, the read selects auxiliary RAM if `altZp`=1 and base RAM otherwise.
- R8: For D000–FFFF writes, no select is asserted when `lcWriteInhibit`=1. When `lcWriteInhibit`=0, the write selects auxiliary RAM if `altZp`=1 and base RAM otherwise. ROM is never selected by a write.
- R9: `ramAddr` equals `addr`, with one exception. When `addr` is in D000–DFFF and `lcBank2`=0, `ramAddr` equals `addr` minus 0x1000, which places it in C000–CFFF. E000–FFFF is never remapped.
- R10: At most one of the four selects is high for any input. Exactly one is high, except in the R6 window and for inhibited writes under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address |
| isWrite | input | 1 | 1 for a write access, 0 for a read |
| altZp | input | 1 | Zero page, stack and language-card RAM go to the auxiliary bank |
| auxRead | input | 1 | General RAM reads go to the auxiliary bank |
| auxWrite | input | 1 | General RAM writes go to the auxiliary bank |
| store80 | input | 1 | The page flags steer the display pages |
| page2 | input | 1 | Second display page selected |
| hiRes | input | 1 | Graphics mode; extends the page2 steering to 2000–3FFF |
| lcBank2 | input | 1 | Second 4 KB bank visible in D000–DFFF |
| lcReadRam | input | 1 | Language-card reads come from RAM instead of ROM |
| lcWriteInhibit | input | 1 | Language-card writes are blocked |
| selBase | output | 1 | Base RAM selected |
| selAux | output | 1 | Auxiliary RAM selected |
| selRom | output | 1 | Internal ROM selected |
| selIo | output | 1 | I/O space selected |
| ramAddr | output | 16 | Physical RAM address after the bank fold |

## Verification
Two functions meet in the same decode: the display-store override and the read/write flag routing. Both act on the display pages, so the bench drives accesses into 0400–07FF and 2000–3FFF with the override on and then off. Each time it gives `auxRead` and `auxWrite` opposite values, so a wrong choice of which rule wins shows up as the wrong bank. The language-card window works the same way. The bank fold of the address and the RAM/ROM/inhibit choice are both active there, so the bench checks the select lines and `ramAddr` together, for every flag combination, against an independent reference model.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W = 16;
  localparam int BANK_W = 12;

  localparam logic [ADDR_W-1:0] ZP_END     = 16'h01FF;
  localparam logic [ADDR_W-1:0] TEXT_LO    = 16'h0400;
  localparam logic [ADDR_W-1:0] TEXT_HI    = 16'h07FF;
  localparam logic [ADDR_W-1:0] HIRES_LO   = 16'h2000;
  localparam logic [ADDR_W-1:0] HIRES_HI   = 16'h3FFF;
  localparam logic [ADDR_W-1:0] IO_LO      = 16'hC000;
  localparam logic [ADDR_W-1:0] IO_HI      = 16'hC0FF;
  localparam logic [ADDR_W-1:0] SLOT_HI    = 16'hCFFF;
  localparam logic [ADDR_W-1:0] LCBANK_HI  = 16'hDFFF;
  localparam logic [ADDR_W-1:0] FOLD_DELTA = 16'h1000;

  typedef enum logic [2:0] {
    REG_ZP, REG_TEXT, REG_HIRES, REG_GEN,
    REG_IO, REG_SLOT, REG_LCBANK, REG_LCHIGH
  } region_e;

  typedef struct packed {
    logic selBase;
    logic selAux;
    logic selRom;
    logic selIo;
    logic foldLow;
  } route_t;
endpackage

// File: rtl/bank_region_dec.sv
module bank_region_dec
  import bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    if (addr <= ZP_END)                          region = REG_ZP;
    else if (addr >= TEXT_LO && addr <= TEXT_HI) region = REG_TEXT;
    else if (addr >= HIRES_LO && addr <= HIRES_HI) region = REG_HIRES;
    else if (addr < IO_LO)                       region = REG_GEN;
    else if (addr <= IO_HI)                      region = REG_IO;
    else if (addr <= SLOT_HI)                    region = REG_SLOT;
    else if (addr <= LCBANK_HI)                  region = REG_LCBANK;
    else                                         region = REG_LCHIGH;
  end
endmodule

// File: rtl/bank_route_ctrl.sv
module bank_route_ctrl
  import bank_pkg::*;
(
  input  region_e region,
  input  logic    isWrite,
  input  logic    altZp,
  input  logic    auxRead,
  input  logic    auxWrite,
  input  logic    store80,
  input  logic    page2,
  input  logic    hiRes,
  input  logic    lcBank2,
  input  logic    lcReadRam,
  input  logic    lcWriteInhibit,
  output route_t  route
);
  logic dirAux;
  logic ramHit;
  logic pickAux;

  assign dirAux = isWrite ? auxWrite : auxRead;

  always_comb begin
    ramHit  = 1'b0;
    pickAux = 1'b0;
    route   = '0;
    unique case (region)
      REG_ZP:    begin ramHit = 1'b1; pickAux = altZp; end
      REG_TEXT:  begin ramHit = 1'b1; pickAux = store80 ? page2 : dirAux; end
      REG_HIRES: begin ramHit = 1'b1; pickAux = store80 ? (page2 & hiRes) : dirAux; end
      REG_GEN:   begin ramHit = 1'b1; pickAux = dirAux; end
      REG_IO:    route.selIo = 1'b1;
      REG_SLOT:  ;
      REG_LCBANK, REG_LCHIGH: begin
        pickAux = altZp;
        if (isWrite)        ramHit = !lcWriteInhibit;
        else if (lcReadRam) ramHit = 1'b1;
        else                route.selRom = 1'b1;
      end
      default: ;
    endcase
    route.selAux  = ramHit & pickAux;
    route.selBase = ramHit & !pickAux;
    route.foldLow = (region == REG_LCBANK) & !lcBank2;
  end

  // R10
  always_comb begin
    one_target_chk: assert ($onehot0({route.selBase, route.selAux, route.selRom, route.selIo}))
      else $error("more than one target selected");
  end

  // R8
  always_comb begin
    no_rom_write_chk: assert (!(isWrite && route.selRom))
      else $error("ROM selected on a write");
  end

  // R5
  always_comb begin
    io_region_chk: assert (route.selIo == (region == REG_IO))
      else $error("I/O select outside the I/O window");
  end

  // R6
  always_comb begin
    slot_quiet_chk: assert (!(region == REG_SLOT) ||
                            !(route.selBase | route.selAux | route.selRom | route.selIo))
      else $error("select raised in the slot window");
  end
endmodule

// File: rtl/bank_addr_path.sv
module bank_addr_path
  import bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  route_t            route,
  output logic [ADDR_W-1:0] ramAddr
);
  assign ramAddr = route.foldLow ? (addr - FOLD_DELTA) : addr;

  // R9
  always_comb begin
    fold_offset_chk: assert (ramAddr[BANK_W-1:0] == addr[BANK_W-1:0])
      else $error("bank fold altered the in-bank offset");
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
(
  input  logic [15:0] addr,
  input  logic        isWrite,
  input  logic        altZp,
  input  logic        auxRead,
  input  logic        auxWrite,
  input  logic        store80,
  input  logic        page2,
  input  logic        hiRes,
  input  logic        lcBank2,
  input  logic        lcReadRam,
  input  logic        lcWriteInhibit,
  output logic        selBase,
  output logic        selAux,
  output logic        selRom,
  output logic        selIo,
  output logic [15:0] ramAddr
);
  region_e region;
  route_t  route;

  bank_region_dec u_region (.addr(addr), .region(region));

  bank_route_ctrl u_ctrl (
    .region(region), .isWrite(isWrite), .altZp(altZp), .auxRead(auxRead),
    .auxWrite(auxWrite), .store80(store80), .page2(page2), .hiRes(hiRes),
    .lcBank2(lcBank2), .lcReadRam(lcReadRam), .lcWriteInhibit(lcWriteInhibit),
    .route(route)
  );

  bank_addr_path u_addr (.addr(addr), .route(route), .ramAddr(ramAddr));

  assign selBase = route.selBase;
  assign selAux  = route.selAux;
  assign selRom  = route.selRom;
  assign selIo   = route.selIo;
endmodule

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] addr;
  logic isWrite, altZp, auxRead, auxWrite, store80, page2, hiRes;
  logic lcBank2, lcReadRam, lcWriteInhibit;
  logic selBase, selAux, selRom, selIo;
  logic [15:0] ramAddr;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  bank_decoder u_dut (
    .addr(addr), .isWrite(isWrite), .altZp(altZp), .auxRead(auxRead),
    .auxWrite(auxWrite), .store80(store80), .page2(page2), .hiRes(hiRes),
    .lcBank2(lcBank2), .lcReadRam(lcReadRam), .lcWriteInhibit(lcWriteInhibit),
    .selBase(selBase), .selAux(selAux), .selRom(selRom), .selIo(selIo),
    .ramAddr(ramAddr)
  );

  // flags order: {isWrite, altZp, auxRead, auxWrite, store80, page2, hiRes, lcBank2, lcReadRam, lcWriteInhibit}
  function automatic logic [3:0] refSel(input logic [15:0] a, input logic [9:0] f);
    logic w, az, ar, aw, s80, p2, hr, rr, wi, dir;
    {w, az, ar, aw, s80, p2, hr, rr, wi} = {f[9:3], f[1:0]};
    dir = w ? aw : ar;
    if (a < 16'h0200)                        return az ? 4'b0100 : 4'b1000;
    if (a >= 16'h0400 && a < 16'h0800)       return (s80 ? p2 : dir) ? 4'b0100 : 4'b1000;
    if (a >= 16'h2000 && a < 16'h4000)       return (s80 ? (p2 & hr) : dir) ? 4'b0100 : 4'b1000;
    if (a < 16'hC000)                        return dir ? 4'b0100 : 4'b1000;
    if (a < 16'hC100)                        return 4'b0001;
    if (a < 16'hD000)                        return 4'b0000;
    if (w) return wi ? 4'b0000 : (az ? 4'b0100 : 4'b1000);
    return !rr ? 4'b0010 : (az ? 4'b0100 : 4'b1000);
  endfunction

  function automatic logic [15:0] refAddr(input logic [15:0] a, input logic bank2);
    if (a >= 16'hD000 && a < 16'hE000 && !bank2) return a - 16'h1000;
    return a;
  endfunction

  function automatic string tagOf(input logic [15:0] a, input logic w);
    if (a < 16'h0200) return "R1";
    if (a >= 16'h0400 && a < 16'h0800) return "R3";
    if (a >= 16'h2000 && a < 16'h4000) return "R4";
    if (a < 16'hC000) return "R2";
    if (a < 16'hC100) return "R5";
    if (a < 16'hD000) return "R6";
    return w ? "R8" : "R7";
  endfunction

  task automatic applyCheck(input logic [15:0] a, input logic [9:0] f);
    logic [3:0] expS, gotS;
    logic [15:0] expA;
    @(posedge clk); #1;
    addr = a;
    {isWrite, altZp, auxRead, auxWrite, store80, page2, hiRes, lcBank2, lcReadRam, lcWriteInhibit} = f;
    @(negedge clk);
    expS = refSel(a, f);
    expA = refAddr(a, f[2]);
    gotS = {selBase, selAux, selRom, selIo};
    nVec++;
    if (gotS !== expS) begin
      nBad++;
      $display("FAIL %s addr=%h flags=%b sel got=%b exp=%b", tagOf(a, f[9]), a, f, gotS, expS);
    end
    if (ramAddr !== expA) begin
      nBad++;
      $display("FAIL R9 addr=%h flags=%b ramAddr got=%h exp=%h", a, f, ramAddr, expA);
    end
    if ($countones(gotS) > 1) begin
      nBad++;
      $display("FAIL R10 addr=%h sel got=%b exp=at most one", a, gotS);
    end
  endtask

  task automatic testReset();
    applyCheck(16'h0000, 10'b0);            // R1 base after reset
  endtask

  task automatic testZeroPage();            // R1
    applyCheck(16'h0042, 10'b0100000000);
    applyCheck(16'h01FF, 10'b1100000000);
    applyCheck(16'h0100, 10'b1011000000);
  endtask

  task automatic testGeneral();             // R2
    applyCheck(16'h0800, 10'b0010000000);
    applyCheck(16'h0800, 10'b1010000000);
    applyCheck(16'hBFFF, 10'b1001000000);
    applyCheck(16'h0200, 10'b0001000000);
  endtask

  task automatic testDisplayOverride();     // R3 R4: store80 vs auxRead/auxWrite
    applyCheck(16'h0400, 10'b0010100000);
    applyCheck(16'h07FF, 10'b0011110000);
    applyCheck(16'h0500, 10'b1001000000);
    applyCheck(16'h2000, 10'b0001110000);
    applyCheck(16'h3FFF, 10'b1010111000);
    applyCheck(16'h3000, 10'b0010101000);
  endtask

  task automatic testIoSlot();              // R5 R6
    applyCheck(16'hC000, 10'b1111111111);
    applyCheck(16'hC0FF, 10'b0000000000);
    applyCheck(16'hC100, 10'b0111111111);
    applyCheck(16'hCFFF, 10'b1000000000);
  endtask

  task automatic testLangCard();            // R7 R8 R9
    applyCheck(16'hD000, 10'b0000000000);
    applyCheck(16'hD123, 10'b0100000010);
    applyCheck(16'hDFFF, 10'b0000000110);
    applyCheck(16'hE000, 10'b1000000001);
    applyCheck(16'hFFFF, 10'b1100000000);
    applyCheck(16'hD800, 10'b1000000100);
  endtask

  task automatic testSweep();               // R10 all flag combinations
    logic [15:0] pts [12] = '{16'h0000, 16'h01FF, 16'h0300, 16'h0600, 16'h1000, 16'h2800,
                               16'h9000, 16'hC080, 16'hC300, 16'hD555, 16'hE001, 16'hFFFC};
    for (int f = 0; f < 1024; f++)
      for (int p = 0; p < 12; p++)
        applyCheck(pts[p], f[9:0]);
  endtask

  initial begin
    addr = '0;
    {isWrite, altZp, auxRead, auxWrite, store80, page2, hiRes, lcBank2, lcReadRam, lcWriteInhibit} = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    testReset();
    testZeroPage();
    testGeneral();
    testDisplayOverride();
    testIoSlot();
    testLangCard();
    testSweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nBad++;
        $display("FAIL watchdog: run did not complete got=hung exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule